// File: doc/BRIEF.md
# Tape Drive Status Aggregator

This block holds a small dynamic status word for each of up to eight tape drives and builds a 32-bit controller status from it. The upper half is read as status word 1 and the lower half as status word 2. The drive named by the unit-select input is the one whose dynamic bits show in both words. Two error summaries are derived from different groups of flags. High density and nine-track always read as 1, and two reserved positions always read as 0.

Drive status arrives as an update: a valid strobe, a unit index and a 7-bit dynamic value. If the addressed drive is not attached, the value written is forced to zero. When an update toggles a monitored bit of a drive, a sticky status-change flag is set. Error conditions raised by the controller arrive as a 32-bit set mask that uses the same bit positions as the status words. The latched flags and the change flag stay set until a controller clear or a reset.

Top module: `tsa_status_top`

## Requirements
- R1: After reset every drive word is zero, all latched error flags and the change flag are clear, status word 1 reads 16'h0840 and status word 2 reads the unit field only.
- R2: An update to an attached drive stores upd_dyn, encoded [0]=ready, [1]=write lock, [2]=BOT, [3]=EOF, [4]=EOT, [5]=rewinding, [6]=PE mode. One cycle later, for the selected drive, these bits show at word 1 bit 0 (ready), bit 2 (write lock), bit 7 (BOT), bit 8 (EOF), bit 9 (EOT) and bit 13 (rewinding), and at word 2 bit 0 (PE mode).
- R3: An update addressed to a drive whose attached bit is 0 stores zero, whatever upd_dyn holds.
- R4: The change flag (word 1 bit 3) is set when an update toggles ready, write lock, BOT, rewinding or PE mode. A toggle of EOT or EOF alone does not set it.
- R5: The change flag stays set through later updates and idle cycles until ctl_clr or reset.
- R6: Word 1 bit 15 is 1 exactly when any of these word 1 bits is 1: data late (14), illegal (12), data error (10), EOT (9), EOF (8), BOT (7), bad tape (5), odd character (1).
- R7: Word 2 bit 15 is 1 exactly when any of these word 2 bits is 1: false gap (13), corrected data late (11), bad signal (6), overskew (5), CRC (4), false preamble (2). Runaway (14), word-count overflow (7), single-track error (3) and format error (1) do not set it.
- R8: Word 1 bits 11 (high density) and 6 (nine-track) always read 1. Word 1 bit 4 and word 2 bit 12 always read 0.
- R9: A 1 in err_set at a latchable error position sets that flag from the next cycle on. The latchable positions are word 1 bits 14, 12, 10, 5 and 1 (err_set bits 30, 28, 26, 21, 17) and word 2 bits 14, 13, 11, 7, 6, 5, 4, 3, 2 and 1. A 1 at any other position has no effect.
- R10: Word 2 bits 10:8 carry sel_unit, and the dynamic bits shown are those of drive sel_unit.
- R11: ctl_clr clears every latched error flag and the change flag, and it takes priority over a set in the same cycle. Drive words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_clr | input | 1 | Controller clear of the latched flags and the change flag |
| sel_unit | input | 3 | Drive shown in the status words |
| attached | input | NDRV | Per-drive attached indication |
| upd_valid | input | 1 | Drive status update strobe |
| upd_unit | input | 3 | Drive addressed by the update |
| upd_dyn | input | 7 | New dynamic value for the addressed drive |
| err_set | input | 32 | Error set strobes in status-word bit positions |
| stat_w1 | output | 16 | Status word 1 |
| stat_w2 | output | 16 | Status word 2 |

## Verification
Two cases are hard to reach from the ports. One is an update that changes only EOT or EOF on a drive that is already ready and at BOT, which must leave the change flag clear. The stimulus first clears the flag, then rewrites the drive with only those bits changed. The other is a clear that arrives in the same cycle as an update that toggles a monitored bit. The bench drives both in one step and expects the clear to win. A pseudo-random run over attached and unattached units follows, checked against a model of the bit positions.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int UNIT_W = 3;
    localparam int DYN_W  = 7;

    typedef struct packed {
        logic pem;
        logic rew;
        logic eot;
        logic eof;
        logic bot;
        logic wlk;
        logic rdy;
    } dyn_t;

    // dynamic bits whose toggle raises the change flag
    localparam dyn_t MON_MASK = '{pem: 1'b1, rew: 1'b1, eot: 1'b0, eof: 1'b0,
                                  bot: 1'b1, wlk: 1'b1, rdy: 1'b1};

    // positions held by the sticky error latch
    localparam logic [31:0] LATCH_MASK = 32'h5422_68FE;
    // summary groups, in the positions of each word
    localparam logic [15:0] SUM1_MASK  = 16'h57A2;
    localparam logic [15:0] SUM2_MASK  = 16'h2874;
    // constant ones of word 1
    localparam logic [15:0] W1_FORCED  = 16'h0840;

    // bit positions of word 1
    localparam int W1_SUM = 15;
    localparam int W1_REW = 13;
    localparam int W1_EOT = 9;
    localparam int W1_EOF = 8;
    localparam int W1_BOT = 7;
    localparam int W1_CHG = 3;
    localparam int W1_WLK = 2;
    localparam int W1_RDY = 0;
    // bit positions of word 2
    localparam int W2_SUM  = 15;
    localparam int W2_UNIT = 8;
    localparam int W2_PEM  = 0;
endpackage

// File: rtl/tsa_drive_bank.sv
module tsa_drive_bank
    import tsa_pkg::*;
#(
    parameter int NDRV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [UNIT_W-1:0] upd_unit,
    input  dyn_t              upd_dyn,
    input  logic [NDRV-1:0]   attached,
    input  logic [UNIT_W-1:0] sel_unit,
    output dyn_t              sel_dyn,
    output logic              chg_evt
);
    typedef struct packed {
        dyn_t [NDRV-1:0] drv;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  [NDRV-1:0] hit;
    dyn_t  new_val;

    generate
        for (genvar g = 0; g < NDRV; g++) begin : g_hit
            assign hit[g] = upd_valid && (upd_unit == UNIT_W'(g));
        end
    endgenerate

    always_comb begin
        bank_d  = bank_q;
        chg_evt = 1'b0;
        new_val = '0;
        for (int i = 0; i < NDRV; i++) begin
            if (hit[i]) begin
                new_val = attached[i] ? upd_dyn : '0;
                chg_evt = |((bank_q.drv[i] ^ new_val) & MON_MASK);
                bank_d.drv[i] = new_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        sel_dyn = '0;
        for (int i = 0; i < NDRV; i++) begin
            if (sel_unit == UNIT_W'(i)) sel_dyn = bank_q.drv[i];
        end
    end
endmodule

// File: rtl/tsa_flag_hold.sv
module tsa_flag_hold
    import tsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [31:0] err_set,
    input  logic        chg_evt,
    output logic [31:0] err_flags,
    output logic        chg_flag
);
    typedef struct packed {
        logic [31:0] err;
        logic        chg;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (clr) begin
            hold_d = '0;
        end else begin
            hold_d.err = hold_q.err | (err_set & LATCH_MASK);
            hold_d.chg = hold_q.chg | chg_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign err_flags = hold_q.err;
    assign chg_flag  = hold_q.chg;
endmodule

// File: rtl/tsa_word_build.sv
module tsa_word_build
    import tsa_pkg::*;
(
    input  logic [31:0]       err_flags,
    input  logic              chg_flag,
    input  dyn_t              sel_dyn,
    input  logic [UNIT_W-1:0] sel_unit,
    output logic [15:0]       stat_w1,
    output logic [15:0]       stat_w2
);
    logic [15:0] body1, body2;

    always_comb begin
        body1         = (err_flags[31:16] & LATCH_MASK[31:16]) | W1_FORCED;
        body1[W1_REW] = sel_dyn.rew;
        body1[W1_EOT] = sel_dyn.eot;
        body1[W1_EOF] = sel_dyn.eof;
        body1[W1_BOT] = sel_dyn.bot;
        body1[W1_CHG] = chg_flag;
        body1[W1_WLK] = sel_dyn.wlk;
        body1[W1_RDY] = sel_dyn.rdy;

        body2 = err_flags[15:0] & LATCH_MASK[15:0];
        body2[W2_UNIT +: UNIT_W] = sel_unit;
        body2[W2_PEM] = sel_dyn.pem;

        stat_w1         = body1;
        stat_w1[W1_SUM] = |(body1 & SUM1_MASK);
        stat_w2         = body2;
        stat_w2[W2_SUM] = |(body2 & SUM2_MASK);
    end
endmodule

// File: rtl/tsa_status_top.sv
module tsa_status_top
    import tsa_pkg::*;
#(
    parameter int NDRV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_clr,
    input  logic [2:0]        sel_unit,
    input  logic [NDRV-1:0]   attached,
    input  logic              upd_valid,
    input  logic [2:0]        upd_unit,
    input  logic [6:0]        upd_dyn,
    input  logic [31:0]       err_set,
    output logic [15:0]       stat_w1,
    output logic [15:0]       stat_w2
);
    dyn_t        sel_dyn;
    logic        chg_evt;
    logic [31:0] err_flags;
    logic        chg_flag;

    tsa_drive_bank #(.NDRV(NDRV)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_unit  (upd_unit),
        .upd_dyn   (dyn_t'(upd_dyn)),
        .attached  (attached),
        .sel_unit  (sel_unit),
        .sel_dyn   (sel_dyn),
        .chg_evt   (chg_evt)
    );

    tsa_flag_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctl_clr),
        .err_set   (err_set),
        .chg_evt   (chg_evt),
        .err_flags (err_flags),
        .chg_flag  (chg_flag)
    );

    tsa_word_build u_build (
        .err_flags (err_flags),
        .chg_flag  (chg_flag),
        .sel_dyn   (sel_dyn),
        .sel_unit  (sel_unit),
        .stat_w1   (stat_w1),
        .stat_w2   (stat_w2)
    );
endmodule

// File: rtl/tsa_status_chk.sv
module tsa_status_chk #(
    parameter int NDRV = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_clr,
    input logic [2:0]      sel_unit,
    input logic [NDRV-1:0] attached,
    input logic            upd_valid,
    input logic [2:0]      upd_unit,
    input logic [15:0]     stat_w1,
    input logic [15:0]     stat_w2
);
    logic upd_unattached;
    always_comb begin
        upd_unattached = 1'b0;
        for (int i = 0; i < NDRV; i++)
            if (upd_unit == 3'(i) && !attached[i]) upd_unattached = 1'b1;
    end

    // R8
    forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w1[11] && stat_w1[6] && !stat_w1[4] && !stat_w2[12]);

    // R10
    unit_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w2[10:8] == sel_unit);

    // R5
    chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1[3] && !ctl_clr) |=> stat_w1[3]);

    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr |=> (!stat_w1[3] && ((stat_w1 & 16'h5422) == 16'h0)
                     && ((stat_w2 & 16'h68FE) == 16'h0)));

    // R3
    offline_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_unattached && upd_unit == sel_unit) |=>
        ((sel_unit != $past(sel_unit)) ||
         (((stat_w1 & 16'h2385) == 16'h0) && !stat_w2[0])));
endmodule

bind tsa_status_top tsa_status_chk #(.NDRV(NDRV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_clr   (ctl_clr),
    .sel_unit  (sel_unit),
    .attached  (attached),
    .upd_valid (upd_valid),
    .upd_unit  (upd_unit),
    .stat_w1   (stat_w1),
    .stat_w2   (stat_w2)
);

// File: tb/tsa_status_top_tb.sv
module tsa_status_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_clr = 1'b0;
    logic [2:0]  sel_unit = '0;
    logic [7:0]  attached = 8'b0000_1111;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_unit = '0;
    logic [6:0]  upd_dyn = '0;
    logic [31:0] err_set = '0;
    logic [15:0] stat_w1, stat_w2;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tsa_status_top #(.NDRV(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_clr(ctl_clr), .sel_unit(sel_unit),
        .attached(attached), .upd_valid(upd_valid), .upd_unit(upd_unit),
        .upd_dyn(upd_dyn), .err_set(err_set),
        .stat_w1(stat_w1), .stat_w2(stat_w2)
    );

    typedef struct {
        logic [15:0] w1;
        logic [15:0] w2;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // reference state
    logic [6:0]  m_drv [8];
    logic [31:0] m_err = '0;
    logic        m_chg = 1'b0;

    function automatic logic [15:0] exp_w1(input logic [2:0] s);
        logic [6:0]  d = m_drv[s];
        logic [15:0] w = '0;
        w[14] = m_err[30]; w[12] = m_err[28]; w[10] = m_err[26];
        w[5]  = m_err[21]; w[1]  = m_err[17];
        w[13] = d[5]; w[9] = d[4]; w[8] = d[3]; w[7] = d[2];
        w[2]  = d[1]; w[0] = d[0];
        w[11] = 1'b1; w[6] = 1'b1; w[3] = m_chg;
        w[15] = w[14] | w[12] | w[10] | w[9] | w[8] | w[7] | w[5] | w[1];
        return w;
    endfunction

    function automatic logic [15:0] exp_w2(input logic [2:0] s);
        logic [15:0] w = '0;
        w[14] = m_err[14]; w[13] = m_err[13]; w[11] = m_err[11];
        w[7:1] = m_err[7:1];
        w[10:8] = s;
        w[0] = m_drv[s][6];
        w[15] = w[13] | w[11] | w[6] | w[5] | w[4] | w[2];
        return w;
    endfunction

    task automatic step(input string tag, input logic uv, input logic [2:0] uu,
                        input logic [6:0] ud, input logic [31:0] es,
                        input logic clr, input logic [2:0] sl);
        logic [6:0] nv;
        logic       ev;
        exp_t       e;
        @(negedge clk);
        upd_valid = uv; upd_unit = uu; upd_dyn = ud;
        err_set = es; ctl_clr = clr; sel_unit = sl;
        ev = 1'b0;
        if (uv) begin
            nv = attached[uu] ? ud : 7'h00;
            ev = |((m_drv[uu] ^ nv) & 7'b110_0111);
            m_drv[uu] = nv;
        end
        if (clr) begin
            m_err = '0; m_chg = 1'b0;
        end else begin
            m_err = m_err | (es & 32'h5422_68FE);
            m_chg = m_chg | ev;
        end
        @(posedge clk);
        #1;
        e.w1 = exp_w1(sl); e.w2 = exp_w2(sl); e.tag = tag;
        sb.push_back(e);
        upd_valid = 1'b0; err_set = '0; ctl_clr = 1'b0;
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                e = sb.pop_front();
                n_tests++;
                if (stat_w1 !== e.w1 || stat_w2 !== e.w2) begin
                    n_fail++;
                    $display("FAIL %s: w1=%h w2=%h expected w1=%h w2=%h",
                             e.tag, stat_w1, stat_w2, e.w1, e.w2);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 8; i++) m_drv[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;  // R1 reset state
        if (stat_w1 !== 16'h0840 || stat_w2 !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1: w1=%h w2=%h expected w1=0840 w2=0000", stat_w1, stat_w2);
        end

        // R2 ready+BOT on drive 0, R4 change raised, R6 summary from BOT
        step("R2", 1, 3'd0, 7'h05, '0, 0, 3'd0);
        // R11 clear drops change, keeps drive word
        step("R11", 0, 3'd0, 7'h00, '0, 1, 3'd0);
        // R4 only EOT/EOF toggles: no change flag
        step("R4", 1, 3'd0, 7'h1D, '0, 0, 3'd0);
        // R4 PE mode toggle sets change
        step("R4", 1, 3'd0, 7'h5D, '0, 0, 3'd0);
        // R5 change holds over idle and non-monitored updates
        step("R5", 0, 3'd0, 7'h00, '0, 0, 3'd0);
        step("R5", 1, 3'd0, 7'h4D, '0, 0, 3'd0);
        // R3 unattached drive 4 stays zero
        step("R3", 1, 3'd4, 7'h7F, '0, 0, 3'd4);
        // R10 select drive 2, rewinding only
        step("R11", 0, 3'd0, 7'h00, '0, 1, 3'd2);
        step("R10", 1, 3'd2, 7'h20, '0, 0, 3'd2);
        // R8 and R9: all-ones set mask, reserved stay zero
        step("R8", 0, 3'd0, 7'h00, 32'hFFFF_FFFF, 0, 3'd2);
        step("R11", 0, 3'd0, 7'h00, '0, 1, 3'd2);
        // R7 non-summary flags alone leave summary 2 clear
        step("R7", 0, 3'd0, 7'h00, 32'h0000_408A, 0, 3'd2);
        step("R7", 0, 3'd0, 7'h00, 32'h0000_0010, 0, 3'd2);
        step("R11", 0, 3'd0, 7'h00, '0, 1, 3'd2);
        // R9 set mask on non-latchable positions is ignored
        step("R9", 0, 3'd0, 7'h00, ~32'h5422_68FE, 0, 3'd2);
        // R6 data late alone raises summary 1 on a drive without tape marks
        step("R6", 0, 3'd0, 7'h00, 32'h4000_0000, 0, 3'd2);
        // R11 clear in same cycle as monitored toggle: clear wins
        step("R11", 1, 3'd2, 7'h01, 32'h0020_0000, 1, 3'd2);
        step("R10", 0, 3'd0, 7'h00, '0, 0, 3'd0);

        // R2 pseudo-random updates across attached and unattached drives
        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R2", lf[10], lf[2:0], lf[9:3],
                 (lf[11] ? {lf, lf} : 32'h0), lf[15] & lf[14], lf[2:0] ^ {2'b0, lf[12]});
        end

        repeat (3) @(posedge clk);
        #3;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule